// File: doc/BRIEF.md
# Two-Wire Bus Clear Pulse Generator

This block frees a two-wire serial bus that a slave is holding in a stuck state with its data line pulled low. When software writes a 1 to the clear-request bit, the block drives a fixed burst of sixteen clock pulses onto the clock line. These pulses let the slave finish the byte it was shifting out and release the data line. The block never drives the data line. The clock output is open-drain style: a 1 on `sclDriveLow` pulls the line low, and a 0 releases it.

The widths of the low and high phases come from two 7-bit settings. These settings are loaded through write strobes and are counted in cycles of the local oscillator clock. Each width setting `w` gives a phase of `(w + 1) * 8 + 8` cycles. The settings in force when a burst starts are captured and held for the whole burst. At the end of the burst the block emits a one-cycle completion strobe, which is meant to set a "bus clear done" interrupt cause elsewhere. The request bit clears itself, so the block keeps no request state beyond its busy indication.

Top module: `busClearGen`

## Requirements
- R1: A cycle with `reqWr`=1 and `reqBit`=1 while idle starts a burst. `busy` goes to 1 and `sclDriveLow` goes to 1 from the following cycle, so every pulse begins with its low phase.
- R2: Each low phase lasts exactly `(L + 1) * 8 + 8` clock cycles, where L is the low-width setting captured at the start.
- R3: Each high phase lasts exactly `(H + 1) * 8 + 8` clock cycles, where H is the high-width setting captured at the start.
- R4: After reset the high-width setting is 0x2D and the low-width setting is 0x37. A burst started without any width writes therefore has a 456-cycle low phase and a 376-cycle high phase.
- R5: A burst contains exactly 16 low/high pulses. When the 16th high phase ends, `busy` returns to 0 and the clock line stays released.
- R6: `done` is 1 for exactly one cycle: the first cycle in which `busy` is 0 after a burst.
- R7: A request write of 1 while `busy` is 1 is ignored. The burst keeps its timing and its pulse count.
- R8: A request write with `reqBit`=0 starts nothing. `busy`, `sclDriveLow` and `done` all stay 0.
- R9: Width writes during a burst do not change that burst. They take effect from the next burst.
- R10: `sdaDriveLow` is 0 at all times.
- R11: Reset leaves `sclDriveLow`, `busy` and `done` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqWr | input | 1 | Write strobe for the clear-request bit |
| reqBit | input | 1 | Data value written to the clear-request bit |
| widthWrHigh | input | 1 | Write strobe for the high-width setting |
| widthWrLow | input | 1 | Write strobe for the low-width setting |
| widthWrData | input | 7 | Value written to the selected width setting |
| sclDriveLow | output | 1 | 1 pulls the clock line low, 0 releases it |
| sdaDriveLow | output | 1 | Data line pull-down, held at 0 |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle strobe at the end of a burst |

## Verification
A request sampled at one clock edge shows up on `busy` and `sclDriveLow` right after that edge. From there the clock waveform follows arithmetically: sample k is low while `k mod (low+high)` is below the low length. `busy` stays 1 for exactly `16*(low+high)` samples, and `done` appears on the single sample that follows. The bench drives inputs on falling edges and samples on every falling edge from the first cycle after the request. It compares each sample with that formula, so a phase that is off by one cycle, or an extra or missing pulse, shows up at an exact sample index. Ignored requests and width writes are injected at chosen sample indices in the middle of a burst. The same formula must still hold afterwards, and the next burst is checked against the new widths.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Strobes from the sequencer to the timing datapath
  typedef struct packed {
    logic loadWidths;  // capture width settings into active lengths
    logic clearCnt;    // restart the phase counter
    logic countEn;     // advance the phase counter
    logic selHigh;     // compare against the high-phase length
  } pathCtl_t;
endpackage

// File: rtl/busClearPath.sv
module busClearPath
  import bcg_pkg::*;
#(
  parameter int WBITS = 7,
  parameter logic [WBITS-1:0] HIGH_RST = 7'h2D,
  parameter logic [WBITS-1:0] LOW_RST  = 7'h37
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathCtl_t         ctl,
  input  logic             widthWrHigh,
  input  logic             widthWrLow,
  input  logic [WBITS-1:0] widthWrData,
  output logic             phaseDone
);
  localparam int LBITS = WBITS + 4;

  logic [WBITS-1:0] widthHighQ, widthLowQ;
  logic [LBITS-1:0] lenHighQ, lenLowQ, curLen, cnt;

  function automatic logic [LBITS-1:0] lenOf(input logic [WBITS-1:0] w);
    return LBITS'({w, 3'b000}) + LBITS'(16);
  endfunction

  // Software-visible width settings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthHighQ <= HIGH_RST;
      widthLowQ  <= LOW_RST;
    end else begin
      if (widthWrHigh) widthHighQ <= widthWrData;
      if (widthWrLow)  widthLowQ  <= widthWrData;
    end
  end

  // Active lengths, frozen for one burst
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenHighQ <= '0;
      lenLowQ  <= '0;
    end else if (ctl.loadWidths) begin
      lenHighQ <= lenOf(widthHighQ);
      lenLowQ  <= lenOf(widthLowQ);
    end
  end

  assign curLen    = ctl.selHigh ? lenHighQ : lenLowQ;
  assign phaseDone = ctl.countEn && (cnt == curLen - LBITS'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (ctl.clearCnt) cnt <= '0;
    else if (ctl.countEn)  cnt <= cnt + LBITS'(1);
  end

  // R2 R3: the phase counter never runs past the active length
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.countEn |-> (cnt < curLen));

  // R9
  len_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.countEn && !ctl.loadWidths) |=> ($stable(lenHighQ) && $stable(lenLowQ)));
endmodule

// File: rtl/busClearCtrl.sv
module busClearCtrl
  import bcg_pkg::*;
#(
  parameter int PULSES = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     phaseDone,
  output pathCtl_t ctl,
  output logic     sclLow,
  output logic     busy,
  output logic     done
);
  localparam int PBITS = (PULSES > 1) ? $clog2(PULSES) : 1;

  phase_e           state, stateNext;
  logic [PBITS-1:0] pulseCnt;
  logic             lastPulse, finish;

  assign lastPulse = (pulseCnt == PBITS'(PULSES - 1));
  assign finish    = (state == PH_HIGH) && phaseDone && lastPulse;

  always_comb begin
    stateNext      = state;
    ctl            = '0;
    ctl.countEn    = (state != PH_IDLE);
    ctl.selHigh    = (state == PH_HIGH);
    unique case (state)
      PH_IDLE: if (startReq) begin
        stateNext      = PH_LOW;
        ctl.loadWidths = 1'b1;
        ctl.clearCnt   = 1'b1;
      end
      PH_LOW: if (phaseDone) begin
        stateNext    = PH_HIGH;
        ctl.clearCnt = 1'b1;
      end
      PH_HIGH: if (phaseDone) begin
        stateNext    = lastPulse ? PH_IDLE : PH_LOW;
        ctl.clearCnt = 1'b1;
      end
      default: stateNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PH_IDLE;
      pulseCnt <= '0;
      done     <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= finish;
      if (state == PH_IDLE)
        pulseCnt <= '0;
      else if (state == PH_HIGH && phaseDone)
        pulseCnt <= pulseCnt + PBITS'(1);
    end
  end

  assign sclLow = (state == PH_LOW);
  assign busy   = (state != PH_IDLE);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($fell(busy) && $past(lastPulse)));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !phaseDone) |=> (busy && $stable(pulseCnt)));

  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> sclLow);
endmodule

// File: rtl/busClearGen.sv
module busClearGen
  import bcg_pkg::*;
#(
  parameter int WBITS  = 7,
  parameter int PULSES = 16,
  parameter logic [WBITS-1:0] HIGH_RST = 7'h2D,
  parameter logic [WBITS-1:0] LOW_RST  = 7'h37
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqWr,
  input  logic             reqBit,
  input  logic             widthWrHigh,
  input  logic             widthWrLow,
  input  logic [WBITS-1:0] widthWrData,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic             busy,
  output logic             done
);
  pathCtl_t ctl;
  logic     phaseDone;

  busClearCtrl #(.PULSES(PULSES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (reqWr && reqBit),
    .phaseDone (phaseDone),
    .ctl       (ctl),
    .sclLow    (sclDriveLow),
    .busy      (busy),
    .done      (done)
  );

  busClearPath #(.WBITS(WBITS), .HIGH_RST(HIGH_RST), .LOW_RST(LOW_RST)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .widthWrHigh (widthWrHigh),
    .widthWrLow  (widthWrLow),
    .widthWrData (widthWrData),
    .phaseDone   (phaseDone)
  );

  assign sdaDriveLow = 1'b0;

  // R5
  scl_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclDriveLow |-> busy);

  // R8
  zero_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqWr && !reqBit) |=> !busy);
endmodule

// File: tb/tb_busClearGen.sv
`timescale 1ns/1ps
module tb_busClearGen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqWr = 1'b0, reqBit = 1'b0;
  logic       widthWrHigh = 1'b0, widthWrLow = 1'b0;
  logic [6:0] widthWrData = '0;
  logic       sclDriveLow, sdaDriveLow, busy, done;
  int         nRun = 0, nFail = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  busClearGen dut (
    .clk(clk), .rstN(rstN), .reqWr(reqWr), .reqBit(reqBit),
    .widthWrHigh(widthWrHigh), .widthWrLow(widthWrLow), .widthWrData(widthWrData),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setWidths(input int wl, input int wh);
    @(negedge clk);
    widthWrLow = 1'b1; widthWrData = 7'(wl);
    @(negedge clk);
    widthWrLow = 1'b0; widthWrHigh = 1'b1; widthWrData = 7'(wh);
    @(negedge clk);
    widthWrHigh = 1'b0;
  endtask

  // Start a burst and compare every sample against the formula.
  // injectAt >= 0 writes request=1 and new widths (99,99) at that sample.
  task automatic runBurst(input int wl, input int wh, input int injectAt, input string tag);
    int lenL = (wl + 1) * 8 + 8;
    int lenH = (wh + 1) * 8 + 8;
    int per  = lenL + lenH;
    int total = 16 * per;
    int badScl = 0, badBusy = 0, badDone = 0, badSda = 0, firstBad = -1;
    @(negedge clk);
    reqWr = 1'b1; reqBit = 1'b1;
    @(negedge clk);
    reqWr = 1'b0; reqBit = 1'b0;
    for (int k = 0; k <= total + 1; k++) begin
      bit expScl = (k < total) && ((k % per) < lenL);
      bit expBusy = (k < total);
      bit expDone = (k == total);
      if (sclDriveLow !== expScl) begin badScl++; if (firstBad < 0) firstBad = k; end
      if (busy !== expBusy) badBusy++;
      if (done !== expDone) badDone++;
      if (sdaDriveLow !== 1'b0) badSda++;
      reqWr = 1'b0; widthWrLow = 1'b0; widthWrHigh = 1'b0;
      if (k == injectAt) begin
        reqWr = 1'b1; reqBit = 1'b1;
        widthWrLow = 1'b1; widthWrHigh = 1'b1; widthWrData = 7'd99;
      end
      @(negedge clk);
    end
    reqWr = 1'b0; widthWrLow = 1'b0; widthWrHigh = 1'b0;
    check(badScl == 0, {"R2 R3 R5 scl waveform ", tag}, firstBad, -1);
    check(badBusy == 0, {"R5 busy window ", tag}, badBusy, 0);
    check(badDone == 0, {"R6 done strobe ", tag}, badDone, 0);
    check(badSda == 0, {"R10 sda released ", tag}, badSda, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(sclDriveLow === 1'b0 && busy === 1'b0 && done === 1'b0,
          "R11 reset outputs", {sclDriveLow, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 defaults: low 0x37, high 0x2D
    runBurst(8'h37, 8'h2D, -1, "defaults");

    // R8 write of 0 starts nothing
    begin
      int bad = 0;
      @(negedge clk);
      reqWr = 1'b1; reqBit = 1'b0;
      @(negedge clk);
      reqWr = 1'b0;
      for (int k = 0; k < 40; k++) begin
        if (busy !== 1'b0 || sclDriveLow !== 1'b0 || done !== 1'b0) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R8 zero write ignored", bad, 0);
    end

    // R1 R2 R3 sweep of small widths
    for (int wl = 0; wl < 4; wl++)
      for (int wh = 0; wh < 4; wh++) begin
        setWidths(wl, wh);
        runBurst(wl, wh, -1, "sweep");
      end

    // R7 R9: request and width writes mid-burst are ignored by the running burst
    setWidths(2, 1);
    runBurst(2, 1, 100, "R7 R9 inject");
    // the injected widths (99,99) take effect next burst
    runBurst(99, 99, -1, "R9 next burst");
    setWidths(1, 3);
    runBurst(1, 3, 5, "R7 early inject");
    runBurst(99, 99, -1, "R9 early next");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule